// File: doc/BRIEF.md
# Control-Register Bus Target

This block is the target end of a four-phase control-register bus, as seen from a serial link PHY. A master shares one 16-bit input word across four strobes. One strobe latches the word as an address, one latches it as a data value, one commits the latched data to the register at the latched address, and one returns that register's contents. The target answers each strobe with an acknowledge that it raises after a fixed number of cycles. The acknowledge stays high for as long as the master keeps the strobe up.

Behind the bus sits a small register file at sparse, parameter-chosen addresses, each with its own reset value. The acknowledge latency is a parameter, so a master's timeout and polling paths can be exercised against slow or fast targets. A strobe that overlaps another strobe is treated as a protocol error and is never answered.

Top module: `crbus_target`

## Requirements
- R1: After reset, `ack_o` and `dout_o` are 0. Every implemented register holds its reset value. With the defaults, the registers and their reset values are 0x0030=0x0085, 0x1002=0x4A3F, 0x1006=0x0123 and 0x102D=0x0080.
- R2: When exactly one strobe is sampled high at a clock edge and stays high, `ack_o` is first seen high after the ACK_LAT-th edge, counting that edge as the first. It is low before then.
- R3: Once high, `ack_o` stays high while any strobe is high. It goes low at the first edge at which all strobes are sampled low.
- R4: Completing a capture-address transfer (`cap_addr_i`) latches `din_i` as the target address. That address persists across later transfers until the next capture-address.
- R5: Completing a capture-data transfer (`cap_data_i`) latches `din_i` as pending data and leaves every register unchanged.
- R6: Completing a write transfer (`wr_i`) copies the pending data into the register at the latched address.
- R7: For a read transfer (`rd_i`), `dout_o` equals the addressed register's value from the cycle `ack_o` rises. It stays stable for as long as `ack_o` is high.
- R8: A read of an unimplemented address returns 0, and a write to one changes no register. Both are still acknowledged.
- R9: While two or more strobes are high together, `ack_o` does not rise, and no address, data or register changes.
- R10: A strobe that is dropped, or joined by another strobe, before its acknowledge arrives is abandoned. It is not acknowledged and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_addr_i | input | 1 | Strobe: latch `din_i` as the address |
| cap_data_i | input | 1 | Strobe: latch `din_i` as pending data |
| rd_i | input | 1 | Strobe: read the addressed register |
| wr_i | input | 1 | Strobe: commit pending data to the addressed register |
| din_i | input | 16 | Shared address/data input word |
| dout_o | output | 16 | Read data, valid while `ack_o` is high after a read |
| ack_o | output | 1 | Acknowledge, level-following |

## Verification
Random sequences of write and read transactions are mixed across implemented and unimplemented addresses, and each read is compared with a model of the register file. This separates address decoding from the commit path, and shows that writes to holes are dropped. Directed patterns are also used:
- Capture-data followed by a read without a write shows that latching data is not the same as committing it.
- A read with no fresh capture-address shows that the latched address persists.
- Overlapping strobes, and a strobe dropped before its acknowledge arrives, show that erroneous or abandoned strobes neither get an answer nor touch any state.

Every transfer also measures the acknowledge latency and how long the acknowledge is held.

// File: rtl/crbus_target.sv
module crbus_target #(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int NREG    = 4,
  parameter int ACK_LAT = 3,
  parameter logic [NREG*AW-1:0] REG_ADDR = {16'h102d, 16'h1006, 16'h1002, 16'h0030},
  parameter logic [NREG*DW-1:0] REG_INIT = {16'h0080, 16'h0123, 16'h4a3f, 16'h0085}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_addr_i,
  input  logic          cap_data_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] dout_o,
  output logic          ack_o
);
  localparam int CW = (ACK_LAT < 2) ? 1 : $clog2(ACK_LAT + 1);
  localparam logic [CW-1:0] LAST = CW'(ACK_LAT - 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_ACK} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [3:0]    stb, op_q, op_now;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q, rd_val;
  logic [NREG-1:0] hit;
  logic [DW-1:0] regs [NREG];
  logic          fire;

  assign stb    = {wr_i, rd_i, cap_data_i, cap_addr_i};
  assign op_now = (st == S_IDLE) ? stb : op_q;
  assign fire   = (st == S_IDLE && $onehot(stb) && ACK_LAT <= 1) ||
                  (st == S_WAIT && stb == op_q && cnt == LAST);
  assign ack_o  = (st == S_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      op_q <= '0;
    end else begin
      case (st)
        S_IDLE: if ($onehot(stb)) begin
          op_q <= stb;
          cnt  <= CW'(1);
          st   <= (ACK_LAT <= 1) ? S_ACK : S_WAIT;
        end
        S_WAIT: begin
          if (stb != op_q)      st  <= S_IDLE;
          else if (cnt == LAST) st  <= S_ACK;
          else                  cnt <= cnt + CW'(1);
        end
        S_ACK:   if (stb == 4'b0000) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  genvar g;
  for (g = 0; g < NREG; g++) begin : g_reg
    assign hit[g] = (addr_q == REG_ADDR[g*AW +: AW]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      regs[g] <= REG_INIT[g*DW +: DW];
      else if (fire && op_now[3] && hit[g]) regs[g] <= data_q;
    end
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NREG; i++)
      if (hit[i]) rd_val = rd_val | regs[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      dout_o <= '0;
    end else if (fire) begin
      if (op_now[0]) addr_q <= din_i;
      if (op_now[1]) data_q <= din_i;
      if (op_now[2]) dout_o <= rd_val;
    end
  end
endmodule

module crbus_target_chk #(parameter int DW = 16) (
  input logic          clk,
  input logic          rst_n,
  input logic          cap_addr_i,
  input logic          cap_data_i,
  input logic          rd_i,
  input logic          wr_i,
  input logic [DW-1:0] dout_o,
  input logic          ack_o
);
  logic [3:0] s;
  assign s = {wr_i, rd_i, cap_data_i, cap_addr_i};

  AST_ACK_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> $past(s != 4'b0000)); // R2
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && s != 4'b0000) |=> ack_o); // R3
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && s == 4'b0000) |=> !ack_o); // R3
  AST_READ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && $past(ack_o) && rd_i) |-> $stable(dout_o)); // R7
  AST_NO_ACK_ON_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_o && $countones(s) > 1) |=> !ack_o); // R9
  AST_NO_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_o && s == 4'b0000) |=> !ack_o); // R10
endmodule

bind crbus_target crbus_target_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cap_addr_i(cap_addr_i), .cap_data_i(cap_data_i),
  .rd_i(rd_i), .wr_i(wr_i), .dout_o(dout_o), .ack_o(ack_o));

// File: tb/crbus_target_tb.sv
`timescale 1ns/1ps
module crbus_target_tb;
  localparam int LAT = 3;
  logic clk = 0, rst_n = 0;
  logic cap_a = 0, cap_d = 0, rd = 0, wr = 0;
  logic [15:0] din = 0, dout;
  logic ack;
  int errors = 0, checks = 0;
  bit done = 0;

  logic [15:0] m_addr [4] = '{16'h0030, 16'h1002, 16'h1006, 16'h102d};
  logic [15:0] m_val  [4] = '{16'h0085, 16'h4a3f, 16'h0123, 16'h0080};

  always #2.5 clk = ~clk;

  crbus_target #(.ACK_LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .cap_addr_i(cap_a), .cap_data_i(cap_d),
    .rd_i(rd), .wr_i(wr), .din_i(din), .dout_o(dout), .ack_o(ack));

  function automatic logic [15:0] exp_rd(input logic [15:0] a);
    for (int i = 0; i < 4; i++) if (m_addr[i] == a) return m_val[i];
    return 16'h0000;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_stb(input logic [3:0] s);
    {wr, rd, cap_d, cap_a} = s;
  endtask

  task automatic xfer(input logic [3:0] s, input logic [15:0] d, output logic [15:0] q);
    int n = 0;
    @(negedge clk);
    din = d;
    set_stb(s);
    do begin @(posedge clk); @(negedge clk); n++; end while (!ack && n < 40);
    chk("R2 ack latency", n, LAT);
    q = dout;
    @(posedge clk); @(negedge clk);
    chk("R3 ack held", ack, 1);
    if (s[2]) chk("R7 dout stable", dout, q);
    set_stb(4'b0000);
    @(posedge clk); @(negedge clk);
    chk("R3 ack release", ack, 0);
  endtask

  task automatic wr_reg(input logic [15:0] a, input logic [15:0] d);
    logic [15:0] q;
    xfer(4'b0001, a, q);
    xfer(4'b0010, d, q);
    xfer(4'b1000, 16'h0, q);
    for (int i = 0; i < 4; i++) if (m_addr[i] == a) m_val[i] = d;
  endtask

  task automatic rd_reg(input logic [15:0] a, input string req);
    logic [15:0] q;
    xfer(4'b0001, a, q);
    xfer(4'b0100, 16'h0, q);
    chk(req, q, exp_rd(a));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] q;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 ack reset", ack, 0);
    chk("R1 dout reset", dout, 0);
    rst_n = 1;
    for (int i = 0; i < 4; i++) rd_reg(m_addr[i], "R1 reset value");

    wr_reg(16'h1002, 16'hbeef);
    rd_reg(16'h1002, "R6 write commit");

    // R5: capture data without write, then read the same address
    xfer(4'b0001, 16'h1006, q);
    xfer(4'b0010, 16'h5555, q);
    xfer(4'b0100, 16'h0, q);
    chk("R5 capture does not commit", q, exp_rd(16'h1006));
    // R4: address persists; write with no fresh capture-address
    xfer(4'b1000, 16'h0, q);
    m_val[2] = 16'h5555;
    xfer(4'b0100, 16'hffff, q);
    chk("R4 address persists", q, 16'h5555);

    // R8: unimplemented addresses
    wr_reg(16'h0031, 16'h1111);
    rd_reg(16'h0031, "R8 hole reads zero");
    for (int i = 0; i < 4; i++) rd_reg(m_addr[i], "R8 hole write ignored");

    // R9: two strobes together
    xfer(4'b0001, 16'h0030, q);
    @(negedge clk);
    din = 16'h102d;
    set_stb(4'b1001);
    for (int k = 0; k < LAT + 3; k++) begin
      @(posedge clk); @(negedge clk);
      chk("R9 no ack on clash", ack, 0);
    end
    set_stb(4'b0000);
    @(posedge clk);
    xfer(4'b0100, 16'h0, q);
    chk("R9 clash changes nothing", q, exp_rd(16'h0030));

    // R10: strobe dropped before its ack
    xfer(4'b0010, 16'h7777, q);
    @(negedge clk);
    set_stb(4'b1000);
    for (int k = 0; k < LAT - 1; k++) begin
      @(posedge clk); @(negedge clk);
      chk("R10 no early ack", ack, 0);
    end
    set_stb(4'b0000);
    for (int k = 0; k < LAT + 2; k++) begin
      @(posedge clk); @(negedge clk);
      chk("R10 abandoned", ack, 0);
    end
    xfer(4'b0100, 16'h0, q);
    chk("R10 abandoned write", q, exp_rd(16'h0030));

    // Random mix
    for (int it = 0; it < 60; it++) begin
      logic [15:0] a;
      int r = $urandom_range(0, 5);
      a = (r < 4) ? m_addr[r] : 16'($urandom);
      if ($urandom_range(0, 1)) wr_reg(a, 16'($urandom));
      else rd_reg(a, "R6 R7 R8 random read");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule